// File: doc/BRIEF.md
# ADC Track and Convert Sequencer

This block controls a successive-approximation converter. It decides in which SAR clock cycles the input is sampled and in which cycles a conversion runs. One cycle of `clk` is one SAR clock. A 3-bit trigger-mode field picks the single source that may start a conversion. The sources are a software start strobe, one of four timer overflow pulses, or an external convert-start pin. The pin passes through a synchronizer and an edge detector before it is used.

Two tracking policies are available. In continuous tracking the sample switch is closed whenever no conversion is running. In low-power tracking the sample switch stays open until a start arrives. An internal start then opens a fixed tracking window before the conversion. With the external pin as the source, the tracking window is the low phase of the pin, and the conversion starts on its rising edge. A standby input forces tracking off in either policy.

The conversion itself is modelled only as a fixed count of SAR clocks. The block raises busy on an accepted start and returns a one-cycle done pulse when the conversion ends.

Top module: `adc_track_seq`

## Requirements
- R1: After a synchronous reset, busy, done and conv_en are 0. With lp_track=0 and standby=0, track_en is 1.
- R2: With lp_track=0 and standby=0, track_en is the inverse of conv_en in every cycle.
- R3: trig_mode selects the start source as follows: 000 uses sw_start, 001 uses tmr_ovf[0], 011 uses tmr_ovf[1], 010 uses tmr_ovf[2], 101 uses tmr_ovf[3], and 100 uses ext_pin. A pulse on any source that is not selected starts nothing.
- R4: trig_mode values 110 and 111 accept no start from any source.
- R5: With lp_track=1 and an internal source, a start sampled at clock edge E0 gives TRACK_CLKS cycles with track_en=1 and conv_en=0, then CONV_CLKS cycles with conv_en=1. Done is high in the cycle after edge E0+TRACK_CLKS+CONV_CLKS. With the defaults this is 17 clocks from the start to done.
- R6: With lp_track=0, an accepted start moves directly to conversion: conv_en is 1 in the CONV_CLKS cycles after the start edge.
- R7: Busy rises in the cycle after an accepted start and stays high through tracking and conversion. Busy falls in the same cycle as done, which lasts exactly one cycle. conv_en implies busy.
- R8: A start from any source that arrives while busy is high is dropped. It does not shorten the running conversion, extend it, or queue a new one.
- R9: ext_pin passes through SYNC_STAGES synchronizer flops and an edge detector. With the defaults, a rising edge that is set up before clock edge A is accepted at the third edge counted from A. In continuous tracking, conversion then begins with no tracking window.
- R10: With lp_track=1 and trig_mode=100, in idle track_en follows the inverse of the synchronized pin. The pin's rising edge starts the conversion directly, with no added tracking window.
- R11: standby=1 forces track_en to 0 in all states. It does not stop or lengthen a conversion.
- R12: Every conversion holds conv_en high for exactly CONV_CLKS consecutive cycles unless a reset cuts it short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SAR clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_track | input | 1 | 1 selects low-power tracking, 0 selects continuous tracking |
| trig_mode | input | 3 | Start-source select (encoding in R3/R4) |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 4 | Timer overflow pulses, bit n for timer n |
| ext_pin | input | 1 | Asynchronous external convert-start pin |
| standby | input | 1 | Low-power standby or sleep; forces tracking off |
| track_en | output | 1 | Sample switch closed |
| conv_en | output | 1 | Conversion running |
| busy | output | 1 | Start accepted and cycle not yet finished |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench builds the block with its defaults: TRACK_CLKS=3, CONV_CLKS=14 and SYNC_STAGES=2. With these values the 17-clock low-power span and the three-edge latency of the external pin can be checked at exact cycles. The two reserved mode codes and each mismatched timer index are covered by the vector table. Directed cases cover dropped starts during a conversion, standby during a conversion, and a reset in mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int TMR_COUNT = 4;

    localparam logic [2:0] MODE_SW  = 3'b000;
    localparam logic [2:0] MODE_T0  = 3'b001;
    localparam logic [2:0] MODE_T2  = 3'b010;
    localparam logic [2:0] MODE_T1  = 3'b011;
    localparam logic [2:0] MODE_EXT = 3'b100;
    localparam logic [2:0] MODE_T3  = 3'b101;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TRACK = 2'd1,
        SEQ_CONV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic fire;
        logic is_ext;
    } trig_t;

    // Internal start request for the selected source; reserved codes give 0.
    function automatic logic internal_hit(
        input logic [2:0]           mode,
        input logic                 sw,
        input logic [TMR_COUNT-1:0] tmr
    );
        case (mode)
            MODE_SW: internal_hit = sw;
            MODE_T0: internal_hit = tmr[0];
            MODE_T1: internal_hit = tmr[1];
            MODE_T2: internal_hit = tmr[2];
            MODE_T3: internal_hit = tmr[3];
            default: internal_hit = 1'b0;
        endcase
    endfunction

    function automatic logic is_ext_mode(input logic [2:0] mode);
        is_ext_mode = (mode == MODE_EXT);
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           trig_mode,
    input  logic                 sw_start,
    input  logic [TMR_COUNT-1:0] tmr_ovf,
    input  logic                 ext_pin,
    output trig_t                req,
    output logic                 pin_level
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_rise;

    // Synchronizer chain resets high so a pin held high is not seen as an edge.
    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= ext_pin;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= pin_level;
    end

    assign pin_level = sync_q[SYNC_STAGES-1];
    assign ext_rise  = pin_level & ~prev_q;

    always_comb begin
        req.is_ext = is_ext_mode(trig_mode);
        req.fire   = req.is_ext ? ext_rise
                                : internal_hit(trig_mode, sw_start, tmr_ovf);
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int TRACK_CLKS = 3,
    parameter int CONV_CLKS  = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_track,
    input  trig_t      req,
    output seq_state_e state,
    output logic       done
);

    localparam int CNT_MAX = (TRACK_CLKS > CONV_CLKS) ? TRACK_CLKS : CONV_CLKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] TRK_LOAD = CW'(TRACK_CLKS - 1);
    localparam logic [CW-1:0] CNV_LOAD = CW'(CONV_CLKS - 1);
    localparam bit HAS_WINDOW = (TRACK_CLKS > 0);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done_q, done_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (req.fire) begin
                    if (lp_track && !req.is_ext && HAS_WINDOW) begin
                        state_d = SEQ_TRACK;
                        cnt_d   = TRK_LOAD;
                    end else begin
                        state_d = SEQ_CONV;
                        cnt_d   = CNV_LOAD;
                    end
                end
            end
            SEQ_TRACK: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_CONV;
                    cnt_d   = CNV_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SEQ_CONV: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    assign state = state_q;
    assign done  = done_q;

endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out
    import adc_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       lp_track,
    input  logic       ext_mode,
    input  logic       pin_level,
    input  logic       standby,
    output logic       track_en,
    output logic       conv_en,
    output logic       busy
);

    always_comb begin
        conv_en = (state == SEQ_CONV);
        busy    = (state != SEQ_IDLE);
        if (standby) begin
            track_en = 1'b0;
        end else if (!lp_track) begin
            track_en = !conv_en;
        end else begin
            case (state)
                SEQ_TRACK: track_en = 1'b1;
                SEQ_IDLE:  track_en = ext_mode && !pin_level;
                default:   track_en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/adc_track_seq.sv
module adc_track_seq
    import adc_seq_pkg::*;
#(
    parameter int TRACK_CLKS  = 3,
    parameter int CONV_CLKS   = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_track,
    input  logic [2:0] trig_mode,
    input  logic       sw_start,
    input  logic [3:0] tmr_ovf,
    input  logic       ext_pin,
    input  logic       standby,
    output logic       track_en,
    output logic       conv_en,
    output logic       busy,
    output logic       done
);

    trig_t      req;
    logic       pin_level;
    seq_state_e state;

    adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .trig_mode (trig_mode),
        .sw_start  (sw_start),
        .tmr_ovf   (tmr_ovf),
        .ext_pin   (ext_pin),
        .req       (req),
        .pin_level (pin_level)
    );

    adc_seq_fsm #(.TRACK_CLKS(TRACK_CLKS), .CONV_CLKS(CONV_CLKS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lp_track (lp_track),
        .req      (req),
        .state    (state),
        .done     (done)
    );

    adc_seq_out u_out (
        .state     (state),
        .lp_track  (lp_track),
        .ext_mode  (req.is_ext),
        .pin_level (pin_level),
        .standby   (standby),
        .track_en  (track_en),
        .conv_en   (conv_en),
        .busy      (busy)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CONV_CLKS = 14
) (
    input logic clk,
    input logic rst,
    input logic lp_track,
    input logic standby,
    input logic track_en,
    input logic conv_en,
    input logic busy,
    input logic done
);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (conv_en) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    // R11: standby keeps the sample switch open
    p_standby_off_r11: assert property (@(posedge clk) disable iff (rst)
        standby |-> !track_en);

    // R2: tracking and converting never overlap
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(track_en && conv_en));

    // R2: continuous policy tracks whenever not converting
    p_cont_track_r2: assert property (@(posedge clk) disable iff (rst)
        (!lp_track && !standby && !conv_en) |-> track_en);

    // R7: done marks the cycle busy drops
    p_done_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: converting implies busy
    p_conv_busy_r7: assert property (@(posedge clk) disable iff (rst)
        conv_en |-> busy);

    // R12: each conversion lasts exactly CONV_CLKS cycles
    p_conv_len_r12: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_en) && !$past(rst)) |-> (run_len == 16'(CONV_CLKS)));

endmodule

bind adc_track_seq adc_seq_chk #(.CONV_CLKS(CONV_CLKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lp_track (lp_track),
    .standby  (standby),
    .track_en (track_en),
    .conv_en  (conv_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/adc_track_seq_bench.sv
module adc_track_seq_bench;

    localparam int TRK = 3;
    localparam int CNV = 14;

    typedef struct packed {
        logic [2:0] mode;
        logic       lp;
        logic [2:0] stim;    // 0 software, 1..4 timer 0..3
        logic       accept;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'b000, 1'b0, 3'd0, 1'b1},
        '{3'b001, 1'b0, 3'd1, 1'b1},
        '{3'b011, 1'b1, 3'd2, 1'b1},
        '{3'b010, 1'b1, 3'd3, 1'b1},
        '{3'b101, 1'b0, 3'd4, 1'b1},
        '{3'b000, 1'b1, 3'd0, 1'b1},
        '{3'b001, 1'b1, 3'd2, 1'b0},
        '{3'b110, 1'b0, 3'd0, 1'b0},
        '{3'b111, 1'b1, 3'd1, 1'b0},
        '{3'b100, 1'b0, 3'd0, 1'b0},
        '{3'b010, 1'b0, 3'd1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_track = 1'b0;
    logic [2:0] trig_mode = 3'b000;
    logic       sw_start = 1'b0;
    logic [3:0] tmr_ovf = 4'b0;
    logic       ext_pin = 1'b0;
    logic       standby = 1'b0;
    logic       track_en, conv_en, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_track_seq u_adc_track_seq (
        .clk(clk), .rst(rst), .lp_track(lp_track), .trig_mode(trig_mode),
        .sw_start(sw_start), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .standby(standby), .track_en(track_en), .conv_en(conv_en),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {track_en, conv_en, busy, done};
    endfunction

    task automatic drive_stim(input logic [2:0] s, input logic v);
        if (s == 3'd0) sw_start = v;
        else           tmr_ovf[s-1] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(outs() == 4'b1000, "R1", "outputs after reset", outs(), 4'b1000);

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int t, last;
            bit bad;
            logic [3:0] exp, got;
            int bad_k;
            trig_mode = VEC[v].mode;
            lp_track  = VEC[v].lp;
            @(negedge clk);
            drive_stim(VEC[v].stim, 1'b1);
            @(negedge clk);
            drive_stim(VEC[v].stim, 1'b0);
            t = VEC[v].lp ? TRK : 0;
            last = t + CNV + 1;
            bad = 1'b0; bad_k = 0; exp = '0; got = '0;
            for (int kk = 1; kk <= last; kk++) begin
                logic [3:0] e;
                if (!VEC[v].accept)        e = {~VEC[v].lp, 3'b000};
                else if (kk <= t)          e = 4'b1010;
                else if (kk <= t + CNV)    e = 4'b0110;
                else                       e = {~VEC[v].lp, 3'b001};
                if (!bad && outs() !== e) begin
                    bad = 1'b1; bad_k = kk; exp = e; got = outs();
                end
                @(negedge clk);
            end
            chk(!bad, VEC[v].accept ? (VEC[v].lp ? "R5" : "R6") : "R3/R4",
                $sformatf("vector %0d cycle %0d", v, bad_k), got, exp);
        end
        lp_track = 1'b0; trig_mode = 3'b000;

        // R8: starts while busy are dropped
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        k = 1;
        repeat (4) begin @(negedge clk); k++; end
        sw_start = 1'b1; tmr_ovf = 4'hF;
        @(negedge clk); k++;
        sw_start = 1'b0; tmr_ovf = 4'h0;
        while (k < CNV + 1) begin @(negedge clk); k++; end
        chk(done == 1'b1 && busy == 1'b0, "R8", "done timing with dropped start",
            {busy, done}, 2'b01);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && conv_en == 1'b0, "R8", "no queued conversion",
            {busy, conv_en}, 0);

        // R9: external pin, continuous tracking
        trig_mode = 3'b100; lp_track = 1'b0; ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        ext_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R9", "no start before third edge", busy, 0);
        @(negedge clk);
        chk(conv_en == 1'b1 && track_en == 1'b0, "R9", "conversion at third edge",
            {conv_en, track_en}, 2'b10);
        repeat (CNV) @(negedge clk);
        chk(done == 1'b1, "R9", "done after external start", done, 1);

        // R10: external pin, low-power tracking
        lp_track = 1'b1;
        @(negedge clk);
        chk(track_en == 1'b0, "R10", "pin high in idle, no tracking", track_en, 0);
        ext_pin = 1'b0;
        @(negedge clk);
        chk(track_en == 1'b0, "R10", "pin low not yet synchronized", track_en, 0);
        @(negedge clk);
        chk(track_en == 1'b1, "R10", "tracking during pin low", track_en, 1);
        ext_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(track_en == 1'b0 && busy == 1'b0, "R10", "synced high, not started",
            {track_en, busy}, 0);
        @(negedge clk);
        chk(outs() == 4'b0110, "R10", "direct conversion on rise", outs(), 4'b0110);
        repeat (CNV) @(negedge clk);
        chk(done == 1'b1, "R10", "done after pin-started conversion", done, 1);
        ext_pin = 1'b0;

        // R11: standby
        trig_mode = 3'b000; lp_track = 1'b0; standby = 1'b1;
        @(negedge clk);
        chk(track_en == 1'b0, "R11", "standby idle tracking", track_en, 0);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        repeat (CNV - 1) @(negedge clk);
        chk(conv_en == 1'b1 && track_en == 1'b0, "R11", "conversion under standby",
            {conv_en, track_en}, 2'b10);
        @(negedge clk);
        chk(done == 1'b1, "R11", "standby conversion length", done, 1);
        standby = 1'b0;

        // R1: reset in mid-conversion
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        repeat (5) @(negedge clk);
        do_reset();
        chk(outs() == 4'b1000, "R1", "reset mid-conversion", outs(), 4'b1000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule